// File: doc/BRIEF.md
# Mode-Configurable SPI Master Engine

This block is a single-master serial peripheral interface controller. A local register interface hands it a transmit byte and a one-cycle start strobe. The block then pulls the active-low slave select low, runs the serial clock for 8 bit cells, shifts the byte out on MOSI most-significant bit first and shifts MISO in at the same time. It reports the received byte with a one-cycle done pulse. Clock polarity and clock phase are configuration inputs, so all four SPI modes are available. The serial clock rate comes from a programmable divider.

A transfer can carry one byte or two. In a two-byte transfer, a second transmit byte follows the first on the same select assertion, which gives the usual 16-clock command-then-reply exchange. There is no handshake with the slave: the engine alone decides when clocking starts and when it stops. A start request that arrives while a transfer is in flight is dropped, and a sticky flag records that this happened.

Top module: `spi_xfer_engine`

## Requirements
- R1: While rst_ni is low: ss_no=1, busy_o=0, done_o=0, collision_o=0, rx_o=0, and sclk_o equals cpol_i.
- R2: While idle, sclk_o follows cpol_i in the same cycle (cpol_i=0 gives a low idle level, cpol_i=1 a high one).
- R3: A start_i sampled while idle pulls ss_no low and raises busy_o on that same clock edge. From that edge, mosi_o carries bit 7 of tx0_i, one half serial period (DIV+1 system clocks) before the first serial clock edge.
- R4: A serial clock edge occurs every DIV+1 system clocks, where DIV is the value of div_i latched at start. Let T be the cycle in which the start edge takes effect; edge k becomes visible (k+1)*(DIV+1) cycles after T. Each byte uses exactly 16 edges, and sclk_o finishes at its idle level.
- R5: With cpha_i=0, the even-numbered edges of a byte (0, 2, …) sample MISO and the odd edges change MOSI. With cpha_i=1, the odd edges sample and the even edges change MOSI.
- R6: Bytes are 8 bits and go out MSB first. rx_o holds the 8 MISO samples of the byte, with the first sample in bit 7.
- R7: done_o is a one-cycle pulse in the cycle after the edge that samples the last bit of a byte, and rx_o holds that byte while done_o is high.
- R8: ss_no returns high, and busy_o low, one half serial period after the final serial clock edge of the transfer.
- R9: With two_byte_i=1 at start, a second byte taken from tx1_i follows directly: 32 edges, two done pulses, and ss_no stays low throughout.
- R10: A start_i sampled while busy_o=1 leaves the running transfer unchanged and sets collision_o. collision_o then stays high until reset. An accepted start never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| div_i | input | DIV_W | Half-period divider; a half serial period is div_i+1 system clocks |
| two_byte_i | input | 1 | Request a second byte under the same select |
| start_i | input | 1 | Start strobe |
| tx0_i | input | 8 | First transmit byte |
| tx1_i | input | 8 | Second transmit byte |
| rx_o | output | 8 | Last received byte |
| done_o | output | 1 | Byte-complete pulse |
| busy_o | output | 1 | Transfer in progress |
| collision_o | output | 1 | Sticky start-while-busy flag |
| sclk_o | output | 1 | Serial clock |
| ss_no | output | 1 | Active-low slave select |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The start edge is taken as cycle 0, and every result is due at a fixed multiple of H = DIV+1 cycles after it:
- the first bit and the select are due in cycle 0;
- edge k is due at (k+1)H;
- the done pulse of byte b is due at (16b+15)H with phase 0, or (16b+16)H with phase 1;
- the release is due at (16n+1)H for an n-byte transfer.

The bench samples on the falling system clock edge, counts cycles from the start edge, and compares each event against those exact cycle numbers rather than waiting for it to appear. A behavioural slave in the bench clocks data on the serial clock itself. It therefore checks the mode-dependent sampling order and the ring exchange of bytes in both directions.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  localparam int BYTE_W = 8;
  localparam int EDGE_W = $clog2(2 * BYTE_W);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_TRAIL = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_xfer_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic two_byte_i,
  input  logic cpol_i,
  input  logic cpha_i,
  input  logic tick_i,
  output logic load_o,
  output logic samp_o,
  output logic drive_o,
  output logic last_o,
  output logic reload_o,
  output logic busy_o,
  output logic sclk_o,
  output logic ss_no,
  output logic collision_o
);
  xfer_state_e       state_q;
  logic [EDGE_W-1:0] edge_q;
  logic              more_q;
  logic              cpha_q;
  logic              sclk_q;
  logic              ss_n_q;
  logic              coll_q;
  logic              edge_ev;
  logic              byte_end;

  assign busy_o   = (state_q != ST_IDLE);
  assign load_o   = start_i && !busy_o;
  assign edge_ev  = tick_i && (state_q == ST_RUN);
  // even edges sample for phase 0, odd edges for phase 1
  assign samp_o   = edge_ev && (edge_q[0] == cpha_q);
  assign drive_o  = edge_ev && (edge_q[0] != cpha_q);
  assign last_o   = samp_o && (&edge_q[EDGE_W-1:1]);
  assign byte_end = edge_ev && (&edge_q);
  assign reload_o = byte_end && more_q;
  assign sclk_o   = busy_o ? sclk_q : cpol_i;
  assign ss_no    = ss_n_q;
  assign collision_o = coll_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      edge_q  <= '0;
      more_q  <= 1'b0;
      cpha_q  <= 1'b0;
      sclk_q  <= 1'b0;
      ss_n_q  <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: if (load_o) begin
          state_q <= ST_RUN;
          edge_q  <= '0;
          more_q  <= two_byte_i;
          cpha_q  <= cpha_i;
          sclk_q  <= cpol_i;
          ss_n_q  <= 1'b0;
        end
        ST_RUN: if (tick_i) begin
          sclk_q <= ~sclk_q;
          edge_q <= edge_q + 1'b1;
          if (&edge_q) begin
            if (more_q) more_q  <= 1'b0;
            else        state_q <= ST_TRAIL;
          end
        end
        ST_TRAIL: if (tick_i) begin
          state_q <= ST_IDLE;
          ss_n_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                coll_q <= 1'b0;
    else if (start_i && busy_o) coll_q <= 1'b1;
  end
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit
  import spi_xfer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] tx_i,
  input  logic              reload_i,
  input  logic [BYTE_W-1:0] tx_next_i,
  input  logic              samp_i,
  input  logic              drive_i,
  input  logic              last_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [BYTE_W-1:0] rx_o,
  output logic              done_o
);
  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] rx_q;
  logic              mosi_q;
  logic              done_q;
  logic [BYTE_W-1:0] sh_in;

  assign sh_in  = {sh_q[BYTE_W-2:0], miso_i};
  assign mosi_o = mosi_q;
  assign rx_o   = rx_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      rx_q   <= '0;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        sh_q   <= tx_i;
        mosi_q <= tx_i[BYTE_W-1];
      end else begin
        if (samp_i) begin
          sh_q <= sh_in;
          if (last_i) begin
            rx_q   <= sh_in;
            done_q <= 1'b1;
          end
        end
        // reload wins over the sample shift at a byte boundary
        if (reload_i) sh_q <= tx_next_i;
        if (drive_i)  mosi_q <= reload_i ? tx_next_i[BYTE_W-1] : sh_q[BYTE_W-1];
      end
    end
  end
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_xfer_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             two_byte_i,
  input  logic             start_i,
  input  logic [7:0]       tx0_i,
  input  logic [7:0]       tx1_i,
  output logic [7:0]       rx_o,
  output logic             done_o,
  output logic             busy_o,
  output logic             collision_o,
  output logic             sclk_o,
  output logic             ss_no,
  output logic             mosi_o,
  input  logic             miso_i
);
  logic             half_tick;
  logic             load, samp, drive, last, reload;
  logic [DIV_W-1:0] div_q;
  logic [7:0]       tx1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      tx1_q <= '0;
    end else if (load) begin
      div_q <= div_i;
      tx1_q <= tx1_i;
    end
  end

  spi_half_timer #(.DIV_W(DIV_W)) timer_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .div_i  (div_q),
    .tick_o (half_tick)
  );

  spi_seq_ctrl ctrl_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .two_byte_i  (two_byte_i),
    .cpol_i      (cpol_i),
    .cpha_i      (cpha_i),
    .tick_i      (half_tick),
    .load_o      (load),
    .samp_o      (samp),
    .drive_o     (drive),
    .last_o      (last),
    .reload_o    (reload),
    .busy_o      (busy_o),
    .sclk_o      (sclk_o),
    .ss_no       (ss_no),
    .collision_o (collision_o)
  );

  spi_shift_unit shift_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .tx_i      (tx0_i),
    .reload_i  (reload),
    .tx_next_i (tx1_q),
    .samp_i    (samp),
    .drive_i   (drive),
    .last_i    (last),
    .miso_i    (miso_i),
    .mosi_o    (mosi_o),
    .rx_o      (rx_o),
    .done_o    (done_o)
  );
endmodule

// File: rtl/spi_xfer_engine_chk.sv
module spi_xfer_engine_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic ss_no,
  input logic done_o,
  input logic collision_o,
  input logic sclk_o,
  input logic half_tick
);
  // R3
  start_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> !ss_no && busy_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  done_in_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ss_no);

  // R8
  idle_deselect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> ss_no);

  // R4
  sclk_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ss_no && $past(!ss_no) && !$stable(sclk_o) |-> $past(half_tick));

  // R10
  collision_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && busy_o |=> collision_o);

  // R10
  collision_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collision_o |=> collision_o);
endmodule

bind spi_xfer_engine spi_xfer_engine_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .ss_no       (ss_no),
  .done_o      (done_o),
  .collision_o (collision_o),
  .sclk_o      (sclk_o),
  .half_tick   (half_tick)
);

// File: tb/spi_xfer_engine_tb_top.sv
module spi_xfer_engine_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cpol_i = 1'b0, cpha_i = 1'b0, two_byte_i = 1'b0, start_i = 1'b0;
  logic [7:0] div_i = '0, tx0_i = '0, tx1_i = '0;
  logic [7:0] rx_o;
  logic       done_o, busy_o, collision_o, sclk_o, ss_no, mosi_o;
  logic       miso = 1'b0;

  int n_chk = 0, n_fail = 0, cyc_total = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  spi_xfer_engine #(.DIV_W(8)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cpol_i(cpol_i), .cpha_i(cpha_i),
    .div_i(div_i), .two_byte_i(two_byte_i), .start_i(start_i),
    .tx0_i(tx0_i), .tx1_i(tx1_i), .rx_o(rx_o), .done_o(done_o),
    .busy_o(busy_o), .collision_o(collision_o), .sclk_o(sclk_o),
    .ss_no(ss_no), .mosi_o(mosi_o), .miso_i(miso)
  );

  // behavioural slave clocked by the serial clock
  logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [7:0] sl_tx [2];
  logic [7:0] sl_rx [2];
  logic [7:0] s_out = '0, s_in = '0;
  int         s_bits = 0, s_byte = 0;
  logic       ss_seen = 1'b1, sclk_seen = 1'b0, lead, smp;

  always @(sclk_o or ss_no) begin
    if (ss_no === 1'b0 && ss_seen !== 1'b0) begin
      s_bits = 0; s_byte = 0; sl_rx[0] = '0; sl_rx[1] = '0;
      s_out = sl_tx[0]; miso = s_out[7];
    end else if (ss_no === 1'b0 && sclk_o !== sclk_seen) begin
      lead = (sclk_o != cfg_cpol);
      smp  = lead ^ cfg_cpha;
      if (smp) begin
        s_in = {s_in[6:0], mosi_o};
        s_bits++;
        if (s_bits == 8) begin
          if (s_byte < 2) sl_rx[s_byte] = s_in;
          s_byte++; s_bits = 0;
        end
      end else begin
        if (s_bits == 0) s_out = (s_byte < 2) ? sl_tx[s_byte] : 8'hFF;
        else             s_out = {s_out[6:0], 1'b0};
        miso = s_out[7];
      end
    end
    ss_seen = ss_no; sclk_seen = sclk_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc_total++;
    if (cyc_total > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_total, 100000);
      summary();
    end
  end

  // {cpol, cpha, two, 0, div[3:0], tx0, tx1, slave0, slave1}
  localparam logic [39:0] VEC [8] = '{
    {4'b0000, 4'd0, 8'hA5, 8'h00, 8'h3C, 8'h00},
    {4'b0100, 4'd1, 8'h81, 8'h00, 8'h7E, 8'h00},
    {4'b1000, 4'd2, 8'h0F, 8'h00, 8'hF0, 8'h00},
    {4'b1100, 4'd3, 8'hC3, 8'h00, 8'h96, 8'h00},
    {4'b0010, 4'd1, 8'h9A, 8'h00, 8'h55, 8'hAA},
    {4'b1110, 4'd0, 8'h12, 8'h34, 8'hAB, 8'hCD},
    {4'b0110, 4'd2, 8'hFF, 8'h01, 8'h80, 8'h7F},
    {4'b1010, 4'd1, 8'h6E, 8'hD1, 8'h00, 8'hFF}
  };

  task automatic run_xfer(input logic [39:0] v, input int inj);
    logic       cp = v[39], ch = v[38], two = v[37];
    int         h = int'(v[35:32]) + 1;
    int         nb = two ? 2 : 1;
    logic [7:0] t0 = v[31:24], t1 = v[23:16], s0 = v[15:8], s1 = v[7:0];
    int         edges = 0, dcnt = 0, rel = -1;
    bit         edge_ok = 1, done_ok = 1;
    logic       prev;
    cfg_cpol = cp; cfg_cpha = ch; sl_tx[0] = s0; sl_tx[1] = s1;
    @(negedge clk_i);
    cpol_i = cp; cpha_i = ch; two_byte_i = two; div_i = {4'd0, v[35:32]};
    tx0_i = t0; tx1_i = t1; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    // R3: select, busy and MSB right after the start edge
    chk(ss_no == 1'b0 && busy_o && mosi_o == t0[7], "R3",
        {ss_no, busy_o, mosi_o}, {1'b0, 1'b1, t0[7]});
    prev = sclk_o;
    for (int c = 1; c <= (16 * nb + 1) * h + 4; c++) begin
      @(negedge clk_i);
      if (sclk_o !== prev) begin
        edges++;
        if (c != edges * h) edge_ok = 0;
        prev = sclk_o;
      end
      if (done_o) begin
        if (c != (16 * dcnt + (ch ? 16 : 15)) * h) done_ok = 0;
        if (rx_o != (dcnt == 0 ? s0 : s1)) done_ok = 0;
        dcnt++;
      end
      if (rel < 0 && ss_no) rel = c;
      if (c == inj) begin
        start_i = 1'b1; tx0_i = ~t0; two_byte_i = ~two;
      end else if (c == inj + 1) begin
        start_i = 1'b0;
      end
    end
    // R4 / R5: edge cadence and count per mode
    chk(edge_ok && edges == 16 * nb, "R4 edge timing", edges, 16 * nb);
    chk(sclk_o == cp, "R4 idle level after transfer", sclk_o, cp);
    // R7 / R6: done timing and received data
    chk(done_ok && dcnt == nb, "R7 done pulse and rx_o", dcnt, nb);
    // R8 / R9: release one half period after last edge, no release between bytes
    chk(rel == (16 * nb + 1) * h && !busy_o, two ? "R9 release" : "R8 release",
        rel, (16 * nb + 1) * h);
    // R5 / R6: slave saw MSB-first data sampled on the right edges
    chk(sl_rx[0] == t0, "R5 R6 slave byte0", sl_rx[0], t0);
    if (two) chk(sl_rx[1] == t1, "R9 slave byte1", sl_rx[1], t1);
  endtask

  initial begin
    sl_tx[0] = '0; sl_tx[1] = '0; sl_rx[0] = '0; sl_rx[1] = '0;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk(ss_no && !busy_o && !done_o && !collision_o && rx_o == 8'h00 && sclk_o == cpol_i,
        "R1 reset", {ss_no, busy_o, done_o, collision_o, sclk_o}, 5'b10000);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);

    foreach (VEC[i]) run_xfer(VEC[i], -1);

    // R10: accepted starts never raise the flag
    chk(!collision_o, "R10 no false collision", collision_o, 0);

    // R2: idle level follows polarity input
    cpol_i = 1'b1; #1;
    chk(sclk_o == 1'b1, "R2 idle high", sclk_o, 1);
    @(negedge clk_i); cpol_i = 1'b0; #1;
    chk(sclk_o == 1'b0, "R2 idle low", sclk_o, 0);

    // R10: start while busy is ignored and flagged
    run_xfer({4'b0000, 4'd1, 8'h5A, 8'h00, 8'h3C, 8'h00}, 5);
    chk(collision_o, "R10 collision set", collision_o, 1);
    repeat (6) @(negedge clk_i);
    chk(ss_no && !busy_o && collision_o, "R10 no restart, sticky",
        {ss_no, busy_o, collision_o}, 3'b101);

    // R1: reset clears the sticky flag
    rst_ni = 1'b0; @(negedge clk_i);
    chk(!collision_o && ss_no, "R1 reset clears flag", collision_o, 0);
    rst_ni = 1'b1; @(negedge clk_i);
    summary();
  end
endmodule